// File: doc/BRIEF.md
# Prescaled Down-Counting PWM Timer

This block is a single-channel pulse-width modulation timer. A programmable prescaler, followed by a power-of-two divider chosen by a small code, turns the input clock into a timer tick. Each tick moves a 16-bit counter down by one. When the counter ends a cycle at zero, it either reloads from the period value or, in one-shot mode, stops and drops its own run state. The PWM level compares the live counter against a compare value. That compare value is captured only when the counter loads, so a duty change never tears the cycle that is in flight.

Software-style configuration arrives as plain ports. Enabling is a write strobe with a data bit, and the interrupt flag has its own write-one-to-clear strobe. The outputs are the pin-level PWM signal, the live counter, the run state and the interrupt line. The PWM output can be inverted and is gated by an output enable. The interrupt line is the sticky end-of-cycle flag ANDed with an enable.

Top module: `dcnt_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the timer is stopped, the interrupt line is low and the PWM pin is low.
- R2: While running, the counter decrements by one on each tick. Ticks are spaced (cfg_prescale+1)*D clocks, counted from the start edge. The divider code sets D: 3'b000 gives 2, 3'b001 gives 4, 3'b010 gives 8, 3'b011 gives 16, and any code with bit 2 set gives 1. Between ticks the counter holds.
- R3: A strobe on en_wr with en_wdata=1 while stopped starts the timer on that edge. It loads the counter with cfg_period and latches cfg_compare. The same strobe while running has no effect.
- R4: With cfg_out_en=1, pwm_out is 1 exactly when the counter is above the latched compare value, inverted when cfg_invert=1. With cfg_out_en=0, pwm_out is 0.
- R5: A change of cfg_compare affects pwm_out only after the next start or auto-reload.
- R6: In auto-reload mode (cfg_autoreload=1), a tick seen while the counter is 0 reloads cfg_period and latches cfg_compare again.
- R7: In one-shot mode (cfg_autoreload=0), a tick seen while the counter is 0 stops the timer and leaves the counter at 0. The run state clears itself.
- R8: A tick seen while the counter is 0 sets the interrupt flag. A flag_clr pulse clears it. If both happen on the same edge, the flag ends set.
- R9: irq equals the interrupt flag ANDed with cfg_irq_en.
- R10: A strobe on en_wr with en_wdata=0 while running stops the timer and freezes the counter. A later start reloads cfg_period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prescale | input | 8 | Prescaler value; divides by value+1 |
| cfg_div_sel | input | 3 | Divider code (÷2, ÷4, ÷8, ÷16, or ÷1 when bit 2 set) |
| cfg_period | input | 16 | Counter reload value |
| cfg_compare | input | 16 | Duty compare value, latched at load |
| cfg_autoreload | input | 1 | 1 = auto-reload, 0 = one-shot |
| cfg_invert | input | 1 | Inverts the PWM level |
| cfg_out_en | input | 1 | Gates the PWM level onto pwm_out |
| cfg_irq_en | input | 1 | Gates the interrupt flag onto irq |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write data (1 start, 0 stop) |
| flag_clr | input | 1 | Clears the interrupt flag |
| pwm_out | output | 1 | PWM pin level |
| cnt_value | output | 16 | Live counter value |
| running | output | 1 | Timer run state |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle, the bound checker enforces the following:
- the counter step on a tick and its hold between ticks;
- the load on start and on auto-reload;
- the one-shot stop at zero;
- that the latched compare moves only at a load;
- setting and clearing of the flag, including precedence when both occur;
- the frozen counter after a stop.

The tick spacing for each divider code, the deferred duty change as seen on the pin, the ignored start while running, the inverter and output gating, and the set-over-clear collision at the pin are shown only by the bench scenarios. In those scenarios a behavioural model runs alongside the design and predicts the counter, pin, run state and interrupt line.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RELOAD  = 1'b1
  } tmr_mode_e;

  // Divider ratio for a select code: top bit set bypasses (ratio 1),
  // otherwise the low bits k give 2^(k+1).
  function automatic int unsigned div_ratio(input int unsigned code,
                                            input int unsigned sel_w);
    int unsigned low_mask;
    low_mask = (32'd1 << (sel_w - 1)) - 32'd1;
    if (((code >> (sel_w - 1)) & 32'd1) != 0)
      return 32'd1;
    return 32'd1 << ((code & low_mask) + 32'd1);
  endfunction

  // Last index of the divider count for a select code (ratio - 1).
  function automatic int unsigned div_last_index(input int unsigned code,
                                                 input int unsigned sel_w);
    return div_ratio(code, sel_w) - 32'd1;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PSC_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  import pwm_tmr_pkg::*;

  // Largest ratio is 2^(2^(SEL_W-1)); its last index fits in DCW bits.
  localparam int DCW = 2 ** (SEL_W - 1);

  logic [PSC_W-1:0] psc_cnt;
  logic [DCW-1:0]   div_cnt;
  logic [DCW-1:0]   div_limit;
  logic             psc_hit;
  logic             div_hit;

  assign div_limit = DCW'(div_last_index(int'(div_sel), SEL_W));
  assign psc_hit   = run && (psc_cnt >= psc);
  assign div_hit   = div_cnt >= div_limit;
  assign tick      = psc_hit && div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      psc_cnt <= '0;
    end else if (psc_hit) begin
      psc_cnt <= '0;
    end else begin
      psc_cnt <= psc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_cnt <= '0;
    end else if (psc_hit) begin
      if (div_hit) div_cnt <= '0;
      else         div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_down_core.sv
module pwm_down_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             autoreload,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_q,
  output logic             running,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             wrap_evt,
  output logic             reload_evt
);
  import pwm_tmr_pkg::*;

  tmr_mode_e mode;
  logic      at_zero;

  assign mode       = tmr_mode_e'(autoreload);
  assign at_zero    = (cnt == '0);
  assign start_evt  = start_req && !running;
  assign stop_evt   = stop_req && running;
  assign wrap_evt   = tick && !stop_evt && at_zero;
  assign reload_evt = wrap_evt && (mode == MODE_RELOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      cmp_q   <= '0;
    end else if (start_evt) begin
      running <= 1'b1;
      cnt     <= period;
      cmp_q   <= compare;
    end else if (stop_evt) begin
      running <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        if (mode == MODE_RELOAD) begin
          cnt   <= period;
          cmp_q <= compare;
        end else begin
          running <= 1'b0;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic             invert,
  input  logic             out_en,
  input  logic             irq_en,
  input  logic             wrap_evt,
  input  logic             flag_clr,
  output logic             flag,
  output logic             pwm_out,
  output logic             irq
);

  logic duty_high;

  assign duty_high = cnt > cmp_q;
  assign pwm_out   = out_en && (duty_high ^ invert);
  assign irq       = flag && irq_en;

  // Hardware set takes precedence over the clear strobe.
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (wrap_evt) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/dcnt_pwm_timer.sv
module dcnt_pwm_timer #(
  parameter int PSC_W = 8,
  parameter int SEL_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] cfg_prescale,
  input  logic [SEL_W-1:0] cfg_div_sel,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_compare,
  input  logic             cfg_autoreload,
  input  logic             cfg_invert,
  input  logic             cfg_out_en,
  input  logic             cfg_irq_en,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             flag_clr,
  output logic             pwm_out,
  output logic [CNT_W-1:0] cnt_value,
  output logic             running,
  output logic             irq
);

  logic             tick_w;
  logic             start_w;
  logic             stop_w;
  logic             wrap_w;
  logic             reload_w;
  logic             flag_w;
  logic [CNT_W-1:0] cmp_w;
  logic             run_w;
  logic [CNT_W-1:0] cnt_w;

  pwm_tick_gen #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .psc     (cfg_prescale),
    .div_sel (cfg_div_sel),
    .tick    (tick_w)
  );

  pwm_down_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .start_req  (en_wr && en_wdata),
    .stop_req   (en_wr && !en_wdata),
    .autoreload (cfg_autoreload),
    .period     (cfg_period),
    .compare    (cfg_compare),
    .cnt        (cnt_w),
    .cmp_q      (cmp_w),
    .running    (run_w),
    .start_evt  (start_w),
    .stop_evt   (stop_w),
    .wrap_evt   (wrap_w),
    .reload_evt (reload_w)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_w),
    .cmp_q    (cmp_w),
    .invert   (cfg_invert),
    .out_en   (cfg_out_en),
    .irq_en   (cfg_irq_en),
    .wrap_evt (wrap_w),
    .flag_clr (flag_clr),
    .flag     (flag_w),
    .pwm_out  (pwm_out),
    .irq      (irq)
  );

  assign cnt_value = cnt_w;
  assign running   = run_w;

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             wrap_evt,
  input logic             reload_evt,
  input logic             autoreload,
  input logic             flag_clr,
  input logic             flag,
  input logic             running,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_q
);

  p_tick_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> running);

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_evt && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start_evt) |=> $stable(cnt));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> running && cnt == $past(period));

  p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !reload_evt) |=> $stable(cmp_q));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && autoreload) |=> running && cnt == $past(period));

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !autoreload) |=> !running && cnt == '0);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !wrap_evt) |=> !flag);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !running && $stable(cnt));

endmodule

bind dcnt_pwm_timer pwm_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .start_evt  (start_w),
  .stop_evt   (stop_w),
  .wrap_evt   (wrap_w),
  .reload_evt (reload_w),
  .autoreload (cfg_autoreload),
  .flag_clr   (flag_clr),
  .flag       (flag_w),
  .running    (run_w),
  .period     (cfg_period),
  .cnt        (cnt_w),
  .cmp_q      (cmp_w)
);

// File: tb/sim_dcnt_pwm_timer.sv
`timescale 1ns/1ps
module sim_dcnt_pwm_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_prescale = '0;
  logic [2:0]  cfg_div_sel = 3'b100;
  logic [15:0] cfg_period = '0;
  logic [15:0] cfg_compare = '0;
  logic        cfg_autoreload = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        cfg_out_en = 1'b0;
  logic        cfg_irq_en = 1'b0;
  logic        en_wr = 1'b0;
  logic        en_wdata = 1'b0;
  logic        flag_clr = 1'b0;
  logic        pwm_out;
  logic [15:0] cnt_value;
  logic        running;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dcnt_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
    .cfg_div_sel(cfg_div_sel), .cfg_period(cfg_period),
    .cfg_compare(cfg_compare), .cfg_autoreload(cfg_autoreload),
    .cfg_invert(cfg_invert), .cfg_out_en(cfg_out_en),
    .cfg_irq_en(cfg_irq_en), .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_clr(flag_clr), .pwm_out(pwm_out), .cnt_value(cnt_value),
    .running(running), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Clocks per tick, restated from R2.
  function automatic int clocks_per_tick(input int psc, input int code);
    int d;
    case (code)
      0: d = 2;
      1: d = 4;
      2: d = 8;
      3: d = 16;
      default: d = 1;
    endcase
    return (psc + 1) * d;
  endfunction

  // Behavioural reference, advanced on each rising edge.
  int m_cnt = 0, m_cmp = 0, m_since = 0;
  bit m_run = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_since = 0; m_run = 0; m_flag = 0;
    end else begin
      int n;
      bit tk, st, sp, wr;
      n  = clocks_per_tick(int'(cfg_prescale), int'(cfg_div_sel));
      tk = m_run && ((m_since + 1) % n == 0);
      st = en_wr && en_wdata && !m_run;
      sp = en_wr && !en_wdata && m_run;
      wr = tk && !sp && (m_cnt == 0);
      if (wr) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (st) begin
        m_run = 1; m_cnt = int'(cfg_period); m_cmp = int'(cfg_compare); m_since = 0;
      end else if (sp) begin
        m_run = 0;
      end else if (m_run) begin
        m_since++;
        if (tk) begin
          if (m_cnt == 0) begin
            if (cfg_autoreload) begin
              m_cnt = int'(cfg_period); m_cmp = int'(cfg_compare);
            end else m_run = 0;
          end else m_cnt--;
        end
      end
    end
  end

  // Compare against the model between edges on every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_pwm;
      exp_pwm = cfg_out_en ? (int'(m_cnt > m_cmp) ^ int'(cfg_invert)) : 0;
      chk(int'(cnt_value) == m_cnt, "R2", "counter", int'(cnt_value), m_cnt);
      chk(int'(pwm_out) == exp_pwm, "R4", "pwm_out", int'(pwm_out), exp_pwm);
      chk(running == m_run, "R7", "running", int'(running), int'(m_run));
      chk(int'(irq) == int'(m_flag && cfg_irq_en), "R9", "irq", int'(irq),
          int'(m_flag && cfg_irq_en));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic en_write(input bit v);
    en_wr = 1'b1; en_wdata = v;
    cyc();
    en_wr = 1'b0; en_wdata = 1'b0;
  endtask

  task automatic wait_model_cnt(input int v);
    for (int i = 0; i < 500 && m_cnt != v; i++) cyc();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int k;
    int codes[6] = '{0, 1, 2, 3, 4, 7};
    int base;
    repeat (3) cyc();
    // R1 reset state
    chk(cnt_value == 16'd0, "R1", "reset counter", int'(cnt_value), 0);
    chk(running == 1'b0, "R1", "reset running", int'(running), 0);
    chk(irq == 1'b0, "R1", "reset irq", int'(irq), 0);
    chk(pwm_out == 1'b0, "R1", "reset pwm", int'(pwm_out), 0);
    rst_n = 1'b1;
    cyc();

    // Auto-reload, tick every clock
    cfg_prescale = 8'd0; cfg_div_sel = 3'b100; cfg_period = 16'd5;
    cfg_compare = 16'd2; cfg_autoreload = 1'b1; cfg_out_en = 1'b1;
    cfg_irq_en = 1'b1;
    en_write(1'b1);
    chk(int'(cnt_value) == 5, "R3", "start loads period", int'(cnt_value), 5);
    cyc(); cyc();
    // R5: new compare must not reach the pin until reload
    cfg_compare = 16'd4;
    chk(int'(cnt_value) == 3 && pwm_out == 1'b1, "R5", "deferred compare pwm",
        int'(pwm_out), 1);
    // R3: start while running is ignored
    en_write(1'b1);
    chk(int'(cnt_value) == 2, "R3", "start ignored while running", int'(cnt_value), 2);
    repeat (15) cyc();

    // R8 clear alone, then collision with a set
    wait_model_cnt(3);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk(irq == 1'b0, "R8", "flag cleared", int'(irq), 0);
    wait_model_cnt(0);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk(irq == 1'b1, "R8", "set wins over clear", int'(irq), 1);
    cfg_irq_en = 1'b0; cyc();
    chk(irq == 1'b0, "R9", "irq masked", int'(irq), 0);
    cfg_irq_en = 1'b1;
    cfg_invert = 1'b1; repeat (4) cyc();
    cfg_out_en = 1'b0; repeat (4) cyc();
    chk(pwm_out == 1'b0, "R4", "output gated", int'(pwm_out), 0);
    cfg_out_en = 1'b1; cfg_invert = 1'b0;

    // R10 stop freezes, restart reloads
    en_write(1'b0);
    base = int'(cnt_value);
    repeat (5) cyc();
    chk(int'(cnt_value) == base && !running, "R10", "frozen after stop",
        int'(cnt_value), base);
    cfg_period = 16'd9;
    en_write(1'b1);
    chk(int'(cnt_value) == 9, "R10", "restart reloads", int'(cnt_value), 9);
    en_write(1'b0);

    // R7 one-shot with prescale 2, divide by 2
    cfg_prescale = 8'd2; cfg_div_sel = 3'b000; cfg_period = 16'd3;
    cfg_compare = 16'd1; cfg_autoreload = 1'b0; cfg_invert = 1'b1;
    en_write(1'b1);
    k = 0;
    while (running && k < 500) begin cyc(); k++; end
    chk(k == 24, "R7", "one-shot length in clocks", k, 24);
    chk(cnt_value == 16'd0 && !running, "R7", "stopped at zero", int'(cnt_value), 0);
    repeat (8) cyc();
    cfg_invert = 1'b0;

    // R2 spacing of the first step for each divider code
    cfg_autoreload = 1'b1;
    foreach (codes[i]) begin
      cfg_prescale = 8'd1; cfg_div_sel = 3'(codes[i]); cfg_period = 16'd3;
      en_write(1'b1);
      k = 0;
      while (cnt_value == 16'd3 && k < 500) begin cyc(); k++; end
      chk(k == clocks_per_tick(1, codes[i]), "R2", "tick spacing", k,
          clocks_per_tick(1, codes[i]));
      en_write(1'b0);
    end

    // R6 auto-reload at a slower rate with a period change
    cfg_prescale = 8'd0; cfg_div_sel = 3'b001; cfg_period = 16'd2; cfg_compare = 16'd0;
    en_write(1'b1);
    cfg_period = 16'd4; cfg_compare = 16'd3;
    wait_model_cnt(0);
    wait_model_cnt(4);
    chk(int'(cnt_value) == 4, "R6", "reload takes new period", int'(cnt_value), 4);
    repeat (30) cyc();

    done = 1;
    summary();
  end

endmodule